// File: doc/BRIEF.md
# Page-Aligned Transmit Buffer Reader

This block reads a packet that software has already placed in a local buffer RAM and streams it to a transmit MAC. The packet always starts on a 256-byte page boundary. Software uses a byte-wide register port to program the page number and a 16-bit byte count, then writes a start command. The block issues sequential byte reads to a 16-bit-addressed RAM with one cycle of read latency. It presents each byte on a valid/ready stream, flags the final byte, and pulses `done` once the transfer finishes.

A small prefetch FIFO sits between the RAM and the stream. A stalled consumer therefore never loses or repeats a byte, and the stream can carry one byte per cycle while `tx_ready` stays high. The count is sent exactly as programmed, with no limit at any frame size.

Top module: `txbuf_reader`

## Requirements
- R1: The register port writes byte registers selected by `reg_addr`: 0 is the start page (address bits 15..8), 1 is count bits 7..0, 2 is count bits 15..8, and 3 is the command register. Writing 3 with bit 0 set requests a transfer.
- R2: The first RAM read of a transfer uses address {page, 8'h00}.
- R3: Each later read address is the previous one plus one, and it wraps from 16'hFFFF to 16'h0000.
- R4: The stream carries exactly the programmed number of bytes. They are the RAM contents in ascending address order, and counts above 1500 are not cut short.
- R5: `tx_last` is high on the final byte of a transfer and low on every other byte.
- R6: `done` is high for exactly one cycle. For a non-empty transfer, that cycle is the one after the handshake of the last byte.
- R7: A zero count produces no stream beats, and `done` is high in the cycle after the start command is written.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values. No byte is dropped or repeated.
- R9: While a transfer is active, writes to the page and count registers are ignored and a start command is dropped. A later start reuses the values that were in place before the transfer.
- R10: After reset, `tx_valid`, `done` and `ram_rd_en` are low and no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| ram_rd_en | output | 1 | RAM read request |
| ram_addr | output | 16 | RAM read address |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the request |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the transfer |
| tx_ready | input | 1 | Stream consumer ready |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The timing below counts from the clock edge that captures the start command.
- The first read request is issued in the cycle that follows that edge.
- The first byte becomes valid two edges after it, because one edge latches the RAM data and one edge writes the FIFO.
- `done` rises on the edge after the last handshake, or on the edge after a zero-count start.

The bench samples every output on the falling edge and keeps a one-cycle pending flag for `done`, so each pulse is checked in exactly the cycle it is due. Stream bytes are compared against a queue filled by the driver whenever a handshake is seen, so the checks do not depend on gaps caused by backpressure.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int BYTE_W = 8;
   localparam logic [1:0] SEL_PAGE   = 2'd0;
   localparam logic [1:0] SEL_LEN_LO = 2'd1;
   localparam logic [1:0] SEL_LEN_HI = 2'd2;
   localparam logic [1:0] SEL_CMD    = 2'd3;
   typedef struct packed {
      logic               last;
      logic [BYTE_W-1:0]  data;
   } beat_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
   import txr_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              busy,
   output logic [PAGE_W-1:0] page,
   output logic [LEN_W-1:0]  len,
   output logic              start
);
   if (PAGE_W != BYTE_W) begin : g_bad_page
      $error("PAGE_W must equal one byte");
   end
   if (LEN_W != 2*BYTE_W) begin : g_bad_len
      $error("LEN_W must be two bytes");
   end

   logic open;
   assign open  = we && !busy;
   assign start = open && (sel == SEL_CMD) && wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page <= '0;
         len  <= '0;
      end else if (open) begin
         case (sel)
            SEL_PAGE:   page <= wdata;
            SEL_LEN_LO: len[BYTE_W-1:0] <= wdata;
            SEL_LEN_HI: len[LEN_W-1:BYTE_W] <= wdata;
            default: ;
         endcase
      end
   end

   // R9: programmed values stay put for the whole transfer
   p_regs_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(page) && $stable(len)));
endmodule

// File: rtl/txr_fifo.sv
module txr_fifo
   import txr_pkg::*;
#(
   parameter int DEPTH = 2,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  beat_t            din,
   input  logic             pop,
   output beat_t            dout,
   output logic             nonempty,
   output logic [CNT_W-1:0] count
);
   if (DEPTH < 1 || DEPTH > 16) begin : g_bad_depth
      $error("DEPTH out of range");
   end

   beat_t            mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;

   assign nonempty = (count != '0);
   assign dout     = mem[rp];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) begin
            mem[wp] <= din;
            wp      <= bump(wp);
         end
         if (pop) rp <= bump(rp);
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   // R8: a byte is never written into a full buffer, so none is lost
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ((int'(count) < DEPTH) || pop));
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nonempty);
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch
   import txr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8,
   parameter int LEN_W  = 16,
   localparam int OFS_W = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PAGE_W-1:0] page,
   input  logic [LEN_W-1:0]  len,
   input  logic              credit_ok,
   input  logic              end_beat,
   output logic              issue,
   output logic              issue_last,
   output logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done
);
   if (OFS_W <= 0) begin : g_bad_addr
      $error("ADDR_W must exceed PAGE_W");
   end

   logic [LEN_W-1:0] remaining;

   assign issue      = busy && (remaining != '0) && credit_ok;
   assign issue_last = (remaining == LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr      <= '0;
         remaining <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
      end else if (start) begin
         addr      <= {page, {OFS_W{1'b0}}};
         remaining <= len;
         busy      <= (len != '0);
         done      <= (len == '0);
      end else begin
         done <= end_beat;
         if (end_beat) busy <= 1'b0;
         if (issue) begin
            addr      <= addr + 1'b1;
            remaining <= remaining - 1'b1;
         end
      end
   end

   // checker state: the last address handed to the RAM
   logic [ADDR_W-1:0] prev_addr;
   logic              have_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_addr <= '0;
         have_prev <= 1'b0;
      end else if (start) begin
         have_prev <= 1'b0;
      end else if (issue) begin
         prev_addr <= addr;
         have_prev <= 1'b1;
      end
   end

   // R2: the opening read sits on a page boundary
   p_page_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !have_prev) |-> (addr[OFS_W-1:0] == '0));
   // R3: reads walk upward by one with natural wrap
   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && have_prev) |-> (addr == prev_addr + 1'b1));
   // R6: done is never two cycles wide after a beat-driven finish
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);
endmodule

// File: rtl/txbuf_reader.sv
module txbuf_reader
   import txr_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_W     = 8,
   parameter int LEN_W      = 16,
   parameter int FIFO_DEPTH = 2,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [BYTE_W-1:0] ram_rdata,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              done
);
   if (FIFO_DEPTH < 2) begin : g_bad_fifo
      $error("FIFO_DEPTH below 2 cannot sustain one byte per cycle");
   end

   logic [PAGE_W-1:0] page;
   logic [LEN_W-1:0]  len;
   logic              start, busy, issue, issue_last;
   logic              rd_q, last_q, pop, end_beat, credit_ok;
   logic [CNT_W-1:0]  occ;
   beat_t             head, fill;

   txr_regs #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_addr),
      .wdata(reg_wdata), .busy(busy), .page(page), .len(len),
      .start(start));

   txr_fetch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .page(page), .len(len),
      .credit_ok(credit_ok), .end_beat(end_beat), .issue(issue),
      .issue_last(issue_last), .addr(ram_addr), .busy(busy), .done(done));

   assign ram_rd_en = issue;

   // one request in flight at most per cycle; tag it with the last flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         last_q <= 1'b0;
      end else begin
         rd_q   <= issue;
         last_q <= issue && issue_last;
      end
   end

   assign fill.last = last_q;
   assign fill.data = ram_rdata;
   assign pop       = tx_valid && tx_ready;
   assign end_beat  = pop && tx_last;
   assign credit_ok = (int'(occ) + int'(rd_q) - int'(pop)) < FIFO_DEPTH;

   txr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(rd_q), .din(fill), .pop(pop),
      .dout(head), .nonempty(tx_valid), .count(occ));

   assign tx_data = head.data;
   assign tx_last = head.last;

   // R8: an offered byte is held until taken
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
   // R6: the last handshake is followed by done
   p_last_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      end_beat |=> done);
   // R7: nothing is streamed or read while idle
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!tx_valid && !ram_rd_en));
endmodule

// File: tb/tb_txbuf_reader.sv
module tb_txbuf_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        ram_rd_en;
   logic [15:0] ram_addr;
   logic [7:0]  ram_rdata = '0;
   logic        tx_valid, tx_last, done;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b1;

   int tests = 0;
   int fails = 0;
   logic [8:0] exp_q[$];
   bit   done_pend = 0;
   bit   zero_pend = 0;
   int   rdy_mode = 0;
   logic [7:0] lfsr = 8'h1;
   bit   hold_prev = 0;
   logic [7:0] hold_data;
   logic hold_last;

   always #10 clk = ~clk;   // 50 MHz

   txbuf_reader dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
      .ram_rdata(ram_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last), .tx_ready(tx_ready), .done(done));

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return (a[7:0] + a[15:8] * 8'd3) ^ 8'h3C;
   endfunction

   // RAM model, one cycle read latency
   always @(posedge clk) if (ram_rd_en) ram_rdata <= mem_byte(ram_addr);

   // ready pattern generator
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
         0: tx_ready <= 1'b1;
         1: tx_ready <= lfsr[0] | lfsr[3];
         default: tx_ready <= ~tx_ready;
      endcase
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_pend || done) check(done === done_pend, "R6/R7 done timing", done, done_pend);
         done_pend = (tx_valid && tx_ready && tx_last) || zero_pend;
         zero_pend = 0;
         if (hold_prev)
            check(tx_valid && tx_data == hold_data && tx_last == hold_last,
                  "R8 hold under stall", tx_data, hold_data);
         hold_prev = tx_valid && !tx_ready;
         hold_data = tx_data;
         hold_last = tx_last;
         if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) check(0, "R9 unexpected beat", tx_data, 0);
            else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               check(tx_data == e[7:0], "R4 byte value", tx_data, e[7:0]);  // R2 R3 via address-keyed data
               check(tx_last == e[8], "R5 last flag", tx_last, e[8]);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic expect_bytes(input logic [7:0] page, input int len);
      for (int i = 0; i < len; i++) begin
         logic [15:0] a;
         a = {page, 8'h00} + 16'(i);
         exp_q.push_back({(i == len - 1), mem_byte(a)});
      end
   endtask

   task automatic kick(input int len);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01;
      if (len == 0) zero_pend = 1;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(posedge clk);
      repeat (4) @(posedge clk);
      check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
   endtask

   // R1: program page, count low, count high, then command
   task automatic run(input logic [7:0] page, input int len);
      wr(2'd0, page);
      wr(2'd1, len[7:0]);
      wr(2'd2, len[15:8]);
      expect_bytes(page, len);
      kick(len);
      drain();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!tx_valid && !done && !ram_rd_en, "R10 reset outputs", {tx_valid, done, ram_rd_en}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(!tx_valid && !done && !ram_rd_en, "R10 idle after reset", {tx_valid, done, ram_rd_en}, 0);

      rdy_mode = 0; run(8'h12, 20);        // R1 R2 R4 R5 full rate
      rdy_mode = 2; run(8'h40, 33);        // R8 alternating ready
      rdy_mode = 1; run(8'h07, 1);         // R5 single byte
      rdy_mode = 1; run(8'hFF, 300);       // R3 wrap 0xFFFF -> 0x0000
      rdy_mode = 0; run(8'h20, 0);         // R7 zero count
      rdy_mode = 1; run(8'h03, 1600);      // R4 longer than 1500

      // R9: writes and start while busy are ignored
      rdy_mode = 1;
      wr(2'd0, 8'h10); wr(2'd1, 8'd40); wr(2'd2, 8'd0);
      expect_bytes(8'h10, 40);
      kick(40);
      wr(2'd0, 8'h55); wr(2'd1, 8'd5); wr(2'd2, 8'd1);
      wr(2'd3, 8'h01);
      drain();
      repeat (20) @(posedge clk);
      check(exp_q.size() == 0 && !tx_valid, "R9 dropped start", tx_valid, 0);
      expect_bytes(8'h10, 40);             // R9 old page and count kept
      kick(40);
      drain();

      repeat (5) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule